// File: doc/BRIEF.md
# UART Baud Tick Generator

This block produces the oversampling strobe that paces the transmit and receive shifters of a classic byte-wide UART. A host programs a 16-bit divisor as two bytes through a small register window: a 3-bit address, 8-bit data in and out, and active-low read and write strobes that only act while chip select is low. The count is clocked by an external baud clock. That clock is synchronized into the system clock domain, edge-detected, and qualified by a separate enable input.

Each qualified rising edge of the baud clock steps a down counter. When the counter reaches its last step, the block raises `baud_tick` for one system clock cycle and reloads the divisor. The tick rate is therefore the baud clock rate divided by the divisor, which is sixteen times the serial bit rate. Writing either divisor byte restarts the count from the full new divisor on the following system clock edge. A badly chosen old value therefore never causes a long wait. The divisor bytes are reachable only while the access bit (bit 7) of a line-setup register is set.

Top module: `uart_baud_gen`

## Requirements
- R1: After reset, reads of the line-setup register (address 3) and of both divisor bytes return 0, and `baud_tick` is low.
- R2: With bit 7 of the line-setup register set, a write to address 0 stores the divisor low byte and a write to address 1 stores the high byte; reads of those addresses return the stored bytes.
- R3: With bit 7 of the line-setup register clear, reads of addresses 0 and 1 return 0 and writes to them leave the divisor unchanged.
- R4: A write or read takes effect only in a system clock cycle where `bus_cs_n` is low and the strobe is low. Otherwise `bus_dout` is 0 and no register changes.
- R5: With a nonzero divisor D, the number of ticks after N qualified baud clock rising edges since the last divisor write is floor(N / D).
- R6: Rising edges of `baud_clk` that arrive while `baud_clk_en` is low do not advance the count.
- R7: Every `baud_tick` pulse lasts exactly one system clock cycle.
- R8: A write to either divisor byte reloads the counter with the full divisor on the next system clock edge. This discards any partial count.
- R9: While the divisor is 0, `baud_tick` stays low.
- R10: With a divisor of 1, every qualified baud clock rising edge yields one tick.
- R11: Reading any register has no effect on the count or the tick sequence.
- R12: The line-setup register at address 3 stores and returns all 8 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register address |
| bus_din | input | 8 | Write data |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_dout | output | 8 | Read data, 0 when no read is selected |
| baud_clk | input | 1 | External baud clock, below half the system clock rate |
| baud_clk_en | input | 1 | Count enable for the baud clock |
| baud_tick | output | 1 | One-cycle oversampling strobe |

## Verification
The counter is not visible at the ports. A wrong count, a missed reload or a lost enable shows up as a tick total that departs from floor(N/D) once enough baud clock edges have passed. That departure appears at the latest one divisor period after the fault. The bench therefore compares the running tick total after every burst of edges against a model that restarts on each divisor write. A stuck or stretched tick shows up on the first pulse. A mis-decoded register shows up on the very next readback.

// File: rtl/ubg_pkg.sv
package ubg_pkg;
   localparam int unsigned ADDR_W   = 3;
   localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd0;
   localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd1;
   localparam logic [ADDR_W-1:0] A_SETUP  = 3'd3;
   localparam int unsigned ACCESS_BIT = 7;
endpackage

// File: rtl/ubg_sync_edge.sv
module ubg_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[gi] <= 1'b0;
               else     chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/ubg_regs.sv
module ubg_regs
   import ubg_pkg::*;
#(
   parameter int unsigned BYTE_W   = 8,
   parameter int unsigned DIV_W    = 16,
   parameter bit          READ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] din,
   input  logic              cs_n,
   input  logic              wr_n,
   input  logic              rd_n,
   output logic [BYTE_W-1:0] dout,
   output logic [DIV_W-1:0]  divisor,
   output logic              reload
);
   logic [BYTE_W-1:0] lo_q, hi_q, setup_q;
   logic              wr_hit, rd_hit, access;
   logic [BYTE_W-1:0] rd_mux;

   assign wr_hit = ~cs_n & ~wr_n;
   assign rd_hit = ~cs_n & ~rd_n;
   assign access = setup_q[ACCESS_BIT];

   always_ff @(posedge clk) begin
      if (rst) begin
         lo_q    <= '0;
         hi_q    <= '0;
         setup_q <= '0;
         reload  <= 1'b0;
      end else begin
         reload <= 1'b0;
         if (wr_hit) begin
            if (addr == A_SETUP) setup_q <= din;
            if (access && addr == A_DIV_LO) begin
               lo_q   <= din;
               reload <= 1'b1;
            end
            if (access && addr == A_DIV_HI) begin
               hi_q   <= din;
               reload <= 1'b1;
            end
         end
      end
   end

   assign divisor = {hi_q, lo_q};

   always_comb begin
      rd_mux = '0;
      if (rd_hit) begin
         if (addr == A_SETUP)                 rd_mux = setup_q;
         else if (access && addr == A_DIV_LO) rd_mux = lo_q;
         else if (access && addr == A_DIV_HI) rd_mux = hi_q;
      end
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (rst) dout <= '0;
            else     dout <= rd_mux;
         end
      end else begin : g_rd_comb
         assign dout = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/ubg_counter.sv
module ubg_counter #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] divisor,
   input  logic             reload,
   input  logic             step,
   output logic [DIV_W-1:0] count,
   output logic             tick
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         count <= '0;
         tick  <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (reload) begin
            count <= divisor;
         end else if (step) begin
            if (divisor == '0) begin
               count <= '0;
            end else if (count <= ONE) begin
               tick  <= 1'b1;
               count <= divisor;
            end else begin
               count <= count - ONE;
            end
         end
      end
   end
endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
   import ubg_pkg::*;
#(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          READ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        bus_addr,
   input  logic [BYTE_W-1:0] bus_din,
   input  logic              bus_cs_n,
   input  logic              bus_wr_n,
   input  logic              bus_rd_n,
   output logic [BYTE_W-1:0] bus_dout,
   input  logic              baud_clk,
   input  logic              baud_clk_en,
   output logic              baud_tick
);
   generate
      if (DIV_W != 2 * BYTE_W) begin : g_bad_width
         $error("DIV_W must equal two register bytes");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BYTE_W <= ACCESS_BIT) begin : g_bad_byte
         $error("BYTE_W too narrow for the access bit");
      end
   endgenerate

   logic [DIV_W-1:0] div_value;
   logic [DIV_W-1:0] cnt_value;
   logic             load_req;
   logic             edge_pulse;
   logic             step;

   ubg_regs #(
      .BYTE_W  (BYTE_W),
      .DIV_W   (DIV_W),
      .READ_REG(READ_REG)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .addr   (bus_addr),
      .din    (bus_din),
      .cs_n   (bus_cs_n),
      .wr_n   (bus_wr_n),
      .rd_n   (bus_rd_n),
      .dout   (bus_dout),
      .divisor(div_value),
      .reload (load_req)
   );

   ubg_sync_edge #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_in(baud_clk),
      .rise    (edge_pulse)
   );

   assign step = edge_pulse & baud_clk_en;

   ubg_counter #(
      .DIV_W(DIV_W)
   ) u_cnt (
      .clk    (clk),
      .rst    (rst),
      .divisor(div_value),
      .reload (load_req),
      .step   (step),
      .count  (cnt_value),
      .tick   (baud_tick)
   );
endmodule

// File: rtl/ubg_checker.sv
module ubg_checker #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             bus_cs_n,
   input logic             baud_clk_en,
   input logic             baud_tick,
   input logic             edge_pulse,
   input logic             load_req,
   input logic [DIV_W-1:0] div_value,
   input logic [DIV_W-1:0] cnt_value
);
   AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      baud_tick |=> !baud_tick); // R7

   AST_ZERO_DIV_SILENT: assert property (@(posedge clk) disable iff (rst)
      baud_tick |-> $past(div_value) != '0); // R9

   AST_TICK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
      baud_tick |-> $past(edge_pulse && baud_clk_en)); // R6

   AST_RELOAD_NEXT: assert property (@(posedge clk) disable iff (rst)
      load_req |=> cnt_value == $past(div_value)); // R8

   AST_CS_GATES_WRITE: assert property (@(posedge clk) disable iff (rst)
      bus_cs_n |=> $stable(div_value)); // R4

   AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      !load_req |-> cnt_value <= div_value); // R5
endmodule

bind uart_baud_gen ubg_checker #(.DIV_W(DIV_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bus_cs_n   (bus_cs_n),
   .baud_clk_en(baud_clk_en),
   .baud_tick  (baud_tick),
   .edge_pulse (edge_pulse),
   .load_req   (load_req),
   .div_value  (div_value),
   .cnt_value  (cnt_value)
);

// File: tb/uart_baud_gen_tb.sv
module uart_baud_gen_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_din = '0;
   logic       bus_cs_n = 1'b1;
   logic       bus_wr_n = 1'b1;
   logic       bus_rd_n = 1'b1;
   logic [7:0] bus_dout;
   logic       baud_clk = 1'b0;
   logic       baud_clk_en = 1'b0;
   logic       baud_tick;

   int checks = 0;
   int errors = 0;
   int tick_total = 0;
   bit prev_tick = 1'b0;
   bit done = 1'b0;

   // bench model
   int unsigned m_div = 0;
   int unsigned m_cnt = 0;
   int          m_ticks = 0;
   bit          m_access = 1'b0;
   logic [7:0]  m_lo = '0, m_hi = '0, m_setup = '0;

   uart_baud_gen u_dut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_din(bus_din),
      .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
      .bus_dout(bus_dout), .baud_clk(baud_clk), .baud_clk_en(baud_clk_en),
      .baud_tick(baud_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(negedge clk) begin
      if (!rst) begin
         if (baud_tick) tick_total++;
         if (baud_tick && prev_tick) begin
            errors++;
            $display("FAIL R7: tick wider than one cycle, actual=2+ expected=1");
         end
         prev_tick = baud_tick;
      end
   end

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
      end
   endtask

   function automatic void model_edge(input bit en);
      if (en && m_div != 0) begin
         if (m_cnt <= 1) begin
            m_ticks++;
            m_cnt = m_div;
         end else begin
            m_cnt--;
         end
      end
   endfunction

   function automatic void model_write(input logic [2:0] a, input logic [7:0] d, input bit sel);
      if (!sel) return;
      if (a == 3'd3) begin
         m_setup  = d;
         m_access = d[7];
      end else if (m_access && a == 3'd0) begin
         m_lo = d;
      end else if (m_access && a == 3'd1) begin
         m_hi = d;
      end
      if (m_access && (a == 3'd0 || a == 3'd1)) begin
         m_div = {m_hi, m_lo};
         m_cnt = m_div;
      end
   endfunction

   function automatic int expect_read(input logic [2:0] a);
      if (a == 3'd3) return m_setup;
      if (m_access && a == 3'd0) return m_lo;
      if (m_access && a == 3'd1) return m_hi;
      return 0;
   endfunction

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input bit sel);
      @(negedge clk);
      bus_addr = a; bus_din = d; bus_cs_n = !sel; bus_wr_n = 1'b0;
      @(negedge clk);
      bus_cs_n = 1'b1; bus_wr_n = 1'b1;
      model_write(a, d, sel);
   endtask

   task automatic bus_read(input logic [2:0] a, input bit sel, output int val);
      @(negedge clk);
      bus_addr = a; bus_cs_n = !sel; bus_rd_n = 1'b0;
      #1 val = bus_dout;
      @(negedge clk);
      bus_cs_n = 1'b1; bus_rd_n = 1'b1;
   endtask

   task automatic pulses(input int n, input bit en);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         baud_clk_en = en;
         baud_clk = 1'b1;
         repeat (3) @(negedge clk);
         baud_clk = 1'b0;
         repeat (3) @(negedge clk);
         model_edge(en);
      end
      baud_clk_en = 1'b0;
   endtask

   task automatic set_div(input int unsigned v);
      bus_write(3'd3, 8'h80, 1'b1);
      bus_write(3'd0, v[7:0], 1'b1);
      bus_write(3'd1, v[15:8], 1'b1);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int v;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1: reset state
      check("R1 tick", int'(baud_tick), 0);
      bus_read(3'd3, 1'b1, v); check("R1 setup", v, 0);
      bus_write(3'd3, 8'h80, 1'b1);
      bus_read(3'd0, 1'b1, v); check("R1 lo", v, 0);
      bus_read(3'd1, 1'b1, v); check("R1 hi", v, 0);

      // R9: zero divisor stays silent
      pulses(6, 1'b1);
      check("R9 zero divisor", tick_total, m_ticks);
      check("R9 no tick", tick_total, 0);

      // R2 / R12: register access
      bus_write(3'd0, 8'h5A, 1'b1);
      bus_write(3'd1, 8'hC3, 1'b1);
      bus_read(3'd0, 1'b1, v); check("R2 lo", v, 8'h5A);
      bus_read(3'd1, 1'b1, v); check("R2 hi", v, 8'hC3);
      bus_write(3'd3, 8'hA7, 1'b1);
      bus_read(3'd3, 1'b1, v); check("R12 setup", v, 8'hA7);

      // R3: access bit clear hides latches
      bus_write(3'd3, 8'h03, 1'b1);
      bus_read(3'd0, 1'b1, v); check("R3 hidden lo", v, 0);
      bus_write(3'd0, 8'h11, 1'b1);
      bus_write(3'd1, 8'h22, 1'b1);
      bus_write(3'd3, 8'h80, 1'b1);
      bus_read(3'd0, 1'b1, v); check("R3 lo kept", v, 8'h5A);
      bus_read(3'd1, 1'b1, v); check("R3 hi kept", v, 8'hC3);

      // R4: chip select gating
      bus_write(3'd0, 8'h99, 1'b0);
      bus_read(3'd0, 1'b1, v); check("R4 write ignored", v, 8'h5A);
      bus_read(3'd0, 1'b0, v); check("R4 dout idle", v, 0);

      // R10: divisor 1
      set_div(1);
      tick_total = 0; m_ticks = 0;
      pulses(5, 1'b1);
      check("R10 div1", tick_total, 5);

      // R5 / R6: divisor 3 with enable off
      set_div(3);
      tick_total = 0; m_ticks = 0;
      pulses(7, 1'b1);
      check("R5 div3", tick_total, 2);
      pulses(9, 1'b0);
      check("R6 disabled", tick_total, 2);

      // R8: reload discards partial count
      set_div(4);
      tick_total = 0; m_ticks = 0;
      pulses(3, 1'b1);
      bus_write(3'd0, 8'd4, 1'b1);
      pulses(3, 1'b1);
      check("R8 reload", tick_total, 0);
      pulses(1, 1'b1);
      check("R8 after reload", tick_total, 1);

      // R11: reads do not disturb count
      set_div(3);
      tick_total = 0; m_ticks = 0;
      pulses(2, 1'b1);
      for (int i = 0; i < 4; i++) bus_read(3'(i), 1'b1, v);
      pulses(1, 1'b1);
      check("R11 reads", tick_total, 1);

      // random mix, R5 against model
      tick_total = 0; m_ticks = 0;
      for (int it = 0; it < 40; it++) begin
         int unsigned op = $urandom_range(0, 3);
         case (op)
            0: begin
               int unsigned d = ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 7);
               set_div(d);
            end
            1: pulses($urandom_range(1, 12), $urandom_range(0, 3) != 0);
            2: begin
               logic [2:0] a = 3'($urandom_range(0, 3));
               bus_read(a, 1'b1, v);
               check("R2 random read", v, expect_read(a));
            end
            default: bus_write(3'($urandom_range(0, 1)), 8'($urandom_range(1, 9)),
                               $urandom_range(0, 1) == 1);
         endcase
         check("R5 random ticks", tick_total, m_ticks);
      end

      finish_run();
   end
endmodule